// File: doc/BRIEF.md
# Power-Up Self-Test Sequencer

This block runs a fixed chain of eleven known-answer tests on its own as soon as reset is released, with no operator action. For each test it raises a request with the test's index to an external test engine and waits for one response carrying a pass or fail verdict. When all eleven tests pass, it opens the gates for the module's data paths, control input and cryptographic operations. When any test fails, or a response does not arrive in time, it parks in an error state. In that state every gate stays closed and a 4-bit status code reports the failure. Only a new reset, meaning a power cycle, leaves the error state.

A persistent failure flag is kept in nonvolatile storage outside the block. It is read once at start-up. If the flag shows that an earlier power-up had already failed, any new failure is reported as unrecoverable. The block writes the flag through a one-cycle strobe. It sets the flag when a run fails and clears it when a run passes completely.

Top module: `post_seq`

## Requirements
- R1: While reset is asserted, testReq, pathEnable, cryptoEnable and failed are all 0 and statusCode is 0. In the first cycle after reset is released, testReq is 1 and testSel is 0.
- R2: Tests are requested in this fixed order of testSel: 0 firmware signature check, 1 AES-CBC encrypt, 2 AES-CBC decrypt, 3 SHA-256, 4 SHA-512, 5 DRBG, 6 HMAC-SHA-256, 7 AES-XTS encrypt, 8 AES-XTS decrypt, 9 key wrap, 10 key unwrap. testSel holds its value while a request waits for its response.
- R3: A response is taken on a clock edge where testDone is 1. If testPass is also 1 and the test is not the last one, the request for the next index is presented in the following cycle.
- R4: A response with testPass at 0 moves the block to the error state. failed becomes 1, testReq drops, and statusCode becomes the index plus 1 (1 to 11).
- R5: With a timeout setting T, a test whose response has not arrived during its first max(T,1) request cycles fails as in R4. A response that arrives in the last of those cycles is still accepted.
- R6: pathEnable and cryptoEnable are 1 only after all eleven tests have passed, and statusCode is then 0. Both are 0 while the tests run and in the error state.
- R7: The error state is left only by reset. testDone and testPass have no effect on any output while in it.
- R8: priorFail is sampled only on the first clock edge after reset release. If it was 1 there, any failure in that run reports statusCode 15. Changes of priorFail later in the run have no effect.
- R9: flagWrEn is a one-cycle pulse. It is raised in the first cycle of the error state with flagWrData 1, and in the first cycle of the all-pass state with flagWrData 0. It is never raised otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low power-on reset |
| timeoutCycles | input | TIMEOUT_W | Request cycles allowed per test before it counts as failed |
| priorFail | input | 1 | Persistent flag: the previous power-up failed |
| testReq | output | 1 | Request to the test engine |
| testSel | output | TEST_W | Index of the requested test |
| testDone | input | 1 | Test engine response valid |
| testPass | input | 1 | Verdict that goes with testDone |
| pathEnable | output | 1 | Data in/out and control input allowed |
| cryptoEnable | output | 1 | Cryptographic operations allowed |
| failed | output | 1 | Error state indication |
| statusCode | output | 4 | 0 pass or running, 1 to 11 failing test, 15 unrecoverable |
| flagWrEn | output | 1 | Write strobe for the persistent flag |
| flagWrData | output | 1 | Value to write into the persistent flag |

## Verification
A wrong test index shows on testSel in the same cycle as the request, and a pass/fail mix-up shows one cycle after the response edge on failed or pathEnable. A stale wait counter shows as a failure on a test that answers in its last allowed cycle, or as a request that outlives its timeout. A wrongly latched prior-failure bit shows only when a failure happens, as code 15 instead of the index plus 1 or the other way round. So the bench places failures both with and without a prior failure, and again after priorFail changes in the middle of a run.

// File: rtl/post_pkg.sv
package post_pkg;

  typedef enum logic [1:0] {
    ST_START = 2'd0,
    ST_RUN   = 2'd1,
    ST_PASS  = 2'd2,
    ST_FAIL  = 2'd3
  } postState_e;

  // Control-to-datapath strobes, at most one group active per cycle
  typedef struct packed {
    logic startRun;   // latch prior flag, point at first test
    logic nextTest;   // advance index, restart wait count
    logic waitTick;   // one more cycle without response
    logic markFail;   // capture failure code, request flag set
    logic markPass;   // clear code, request flag clear
  } postStrobe_t;

  // Fixed test order; index value is what testSel carries
  typedef enum logic [3:0] {
    TID_FW_SIG   = 4'd0,
    TID_CBC_ENC  = 4'd1,
    TID_CBC_DEC  = 4'd2,
    TID_SHA256   = 4'd3,
    TID_SHA512   = 4'd4,
    TID_DRBG     = 4'd5,
    TID_HMAC256  = 4'd6,
    TID_XTS_ENC  = 4'd7,
    TID_XTS_DEC  = 4'd8,
    TID_KEYWRAP  = 4'd9,
    TID_KEYUNWRP = 4'd10
  } testId_e;

  localparam int unsigned TEST_COUNT = 11;
  localparam int unsigned CODE_W     = 4;

endpackage

// File: rtl/post_ctrl.sv
module post_ctrl
  import post_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        testDone,
  input  logic        testPass,
  input  logic        lastTest,
  input  logic        timeoutHit,
  output postState_e  state,
  output postStrobe_t stb
);

  postState_e nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_START;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    stb       = '0;
    unique case (state)
      ST_START: begin
        stb.startRun = 1'b1;
        nextState    = ST_RUN;
      end
      ST_RUN: begin
        if (testDone) begin
          if (!testPass) begin
            stb.markFail = 1'b1;
            nextState    = ST_FAIL;
          end else if (lastTest) begin
            stb.markPass = 1'b1;
            nextState    = ST_PASS;
          end else begin
            stb.nextTest = 1'b1;
          end
        end else if (timeoutHit) begin
          stb.markFail = 1'b1;
          nextState    = ST_FAIL;
        end else begin
          stb.waitTick = 1'b1;
        end
      end
      ST_PASS: nextState = ST_PASS;
      ST_FAIL: nextState = ST_FAIL;
      default: nextState = ST_FAIL;
    endcase
  end

endmodule

// File: rtl/post_dpath.sv
module post_dpath
  import post_pkg::*;
#(
  parameter int unsigned TIMEOUT_W = 16,
  parameter int unsigned NUM_TESTS = TEST_COUNT,
  localparam int unsigned TEST_W   = $clog2(NUM_TESTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  postStrobe_t          stb,
  input  logic                 priorFail,
  input  logic [TIMEOUT_W-1:0] timeoutCycles,
  output logic [TEST_W-1:0]    testIdx,
  output logic                 lastTest,
  output logic                 timeoutHit,
  output logic [CODE_W-1:0]    statusCode,
  output logic                 flagWrEn,
  output logic                 flagWrData
);

  localparam logic [CODE_W-1:0] UNRECOVERABLE = '1;
  localparam logic [TEST_W-1:0] LAST_IDX      = TEST_W'(NUM_TESTS - 1);

  logic [TIMEOUT_W-1:0] waitCnt;
  logic                 priorLat;
  logic [TIMEOUT_W:0]   waitNext;

  // test index
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             testIdx <= '0;
    else if (stb.startRun) testIdx <= '0;
    else if (stb.nextTest) testIdx <= testIdx + 1'b1;
  end

  assign lastTest = (testIdx == LAST_IDX);

  // per-test wait counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            waitCnt <= '0;
    else if (stb.startRun | stb.nextTest) waitCnt <= '0;
    else if (stb.waitTick)                waitCnt <= waitCnt + 1'b1;
  end

  assign waitNext   = {1'b0, waitCnt} + 1'b1;
  assign timeoutHit = (waitNext >= {1'b0, timeoutCycles});

  // prior-failure latch, sampled once per run
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             priorLat <= 1'b0;
    else if (stb.startRun) priorLat <= priorFail;
  end

  // status code
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             statusCode <= '0;
    else if (stb.markFail) statusCode <= priorLat ? UNRECOVERABLE
                                                  : CODE_W'(testIdx) + 1'b1;
    else if (stb.markPass) statusCode <= '0;
  end

  // persistent flag write strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagWrEn   <= 1'b0;
      flagWrData <= 1'b0;
    end else begin
      flagWrEn <= stb.markFail | stb.markPass;
      if (stb.markFail | stb.markPass) flagWrData <= stb.markFail;
    end
  end

endmodule

// File: rtl/post_seq.sv
module post_seq
  import post_pkg::*;
#(
  parameter int unsigned TIMEOUT_W = 16,
  parameter int unsigned NUM_TESTS = TEST_COUNT,
  localparam int unsigned TEST_W   = $clog2(NUM_TESTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [TIMEOUT_W-1:0] timeoutCycles,
  input  logic                 priorFail,
  output logic                 testReq,
  output logic [TEST_W-1:0]    testSel,
  input  logic                 testDone,
  input  logic                 testPass,
  output logic                 pathEnable,
  output logic                 cryptoEnable,
  output logic                 failed,
  output logic [CODE_W-1:0]    statusCode,
  output logic                 flagWrEn,
  output logic                 flagWrData
);

  postState_e  state;
  postStrobe_t stb;
  logic        lastTest;
  logic        timeoutHit;

  post_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .testDone   (testDone),
    .testPass   (testPass),
    .lastTest   (lastTest),
    .timeoutHit (timeoutHit),
    .state      (state),
    .stb        (stb)
  );

  post_dpath #(
    .TIMEOUT_W (TIMEOUT_W),
    .NUM_TESTS (NUM_TESTS)
  ) u_dpath (
    .clk           (clk),
    .rstN          (rstN),
    .stb           (stb),
    .priorFail     (priorFail),
    .timeoutCycles (timeoutCycles),
    .testIdx       (testSel),
    .lastTest      (lastTest),
    .timeoutHit    (timeoutHit),
    .statusCode    (statusCode),
    .flagWrEn      (flagWrEn),
    .flagWrData    (flagWrData)
  );

  assign testReq      = (state == ST_RUN);
  assign failed       = (state == ST_FAIL);
  assign pathEnable   = (state == ST_PASS);
  assign cryptoEnable = (state == ST_PASS);

endmodule

// File: rtl/post_seq_chk.sv
module post_seq_chk #(
  parameter int unsigned TIMEOUT_W = 16,
  parameter int unsigned TEST_W    = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [TIMEOUT_W-1:0] timeoutCycles,
  input logic                 testReq,
  input logic [TEST_W-1:0]    testSel,
  input logic                 testDone,
  input logic                 failed,
  input logic [3:0]           statusCode,
  input logic                 pathEnable,
  input logic                 cryptoEnable,
  input logic                 flagWrEn,
  input logic                 flagWrData
);

  logic [TIMEOUT_W:0] reqAge;
  logic [TIMEOUT_W:0] effLimit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      reqAge <= '0;
    else if (!testReq || testDone)  reqAge <= '0;
    else                            reqAge <= reqAge + 1'b1;
  end

  assign effLimit = (timeoutCycles == '0) ? (TIMEOUT_W+1)'(1) : {1'b0, timeoutCycles};

  // R2
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(testReq) && testReq && !$past(testDone)) |-> $stable(testSel));

  // R4
  req_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    testReq |-> (!failed && !pathEnable && !cryptoEnable));

  // R5
  wait_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    testReq |-> (reqAge < effLimit));

  // R6
  enable_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pathEnable || cryptoEnable) |-> (statusCode == 4'd0 && !failed));

  // R7
  fail_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    failed |=> (failed && $stable(statusCode)));

  // R9
  flag_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagWrEn |=> !flagWrEn);

  // R9
  flag_on_fail_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(failed) |-> (flagWrEn && flagWrData));

  // R9
  flag_on_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pathEnable) |-> (flagWrEn && !flagWrData));

endmodule

bind post_seq post_seq_chk #(
  .TIMEOUT_W (TIMEOUT_W),
  .TEST_W    (TEST_W)
) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .timeoutCycles (timeoutCycles),
  .testReq       (testReq),
  .testSel       (testSel),
  .testDone      (testDone),
  .failed        (failed),
  .statusCode    (statusCode),
  .pathEnable    (pathEnable),
  .cryptoEnable  (cryptoEnable),
  .flagWrEn      (flagWrEn),
  .flagWrData    (flagWrData)
);

// File: tb/tb_post_seq.sv
module tb_post_seq;

  localparam int TW = 16;
  localparam int N  = 11;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [TW-1:0] tmo = 16'd8;
  logic          prior = 1'b0;
  logic          done = 1'b0;
  logic          pass = 1'b0;
  logic          testReq, pathEnable, cryptoEnable, failed, flagWrEn, flagWrData;
  logic [3:0]    testSel, statusCode;

  always #5 clk = ~clk;

  post_seq #(.TIMEOUT_W(TW), .NUM_TESTS(N)) dut (
    .clk(clk), .rstN(rstN), .timeoutCycles(tmo), .priorFail(prior),
    .testReq(testReq), .testSel(testSel), .testDone(done), .testPass(pass),
    .pathEnable(pathEnable), .cryptoEnable(cryptoEnable), .failed(failed),
    .statusCode(statusCode), .flagWrEn(flagWrEn), .flagWrData(flagWrData)
  );

  int nChecks = 0;
  int nFails  = 0;

  // test engine behaviour
  int lat [N];
  bit verdict [N];
  int engCnt = 0;
  int lastSel = -1;
  bit stray = 1'b0;

  // reference model: 0 start, 1 run, 2 pass, 3 fail
  int mSt = 0, mIdx = 0, mWait = 0, mCode = 0;
  bit mPrior = 0, mFw = 0, mFd = 0;

  task automatic check(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic setEngine(int l);
    for (int i = 0; i < N; i++) begin
      lat[i] = l;
      verdict[i] = 1'b1;
    end
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic doReset();
    @(negedge clk); #1 rstN = 1'b0;
    @(negedge clk); #2;
    check("R1 reset req", int'(testReq), 0);
    check("R1 reset enable", int'(pathEnable), 0);
    check("R1 reset code", int'(statusCode), 0);
    @(negedge clk); #1 rstN = 1'b1;
    @(negedge clk); #2;
    check("R1 first req", int'(testReq), 1);
    check("R1 first sel", int'(testSel), 0);
  endtask

  // model step, compare, then engine drive; all at the falling edge
  always @(negedge clk) begin
    mFw = 1'b0;
    if (!rstN) begin
      mSt = 0; mIdx = 0; mWait = 0; mCode = 0; mPrior = 0; mFd = 0;
    end else begin
      case (mSt)
        0: begin mSt = 1; mIdx = 0; mWait = 0; mPrior = prior; end
        1: begin
          if (done && pass) begin
            if (mIdx == N - 1) begin mSt = 2; mCode = 0; mFw = 1; mFd = 0; end
            else begin mIdx++; mWait = 0; end
          end else if (done || (mWait + 1 >= int'(tmo))) begin
            mSt = 3; mCode = mPrior ? 15 : mIdx + 1; mFw = 1; mFd = 1;
          end else mWait++;
        end
        default: ;
      endcase
    end
    check("R2 req", int'(testReq), int'(mSt == 1));
    if (mSt == 1) check("R2 sel", int'(testSel), mIdx);
    check("R4 failed", int'(failed), int'(mSt == 3));
    check("R4 code", int'(statusCode), mCode);
    check("R6 path", int'(pathEnable), int'(mSt == 2));
    check("R6 crypto", int'(cryptoEnable), int'(mSt == 2));
    check("R9 wr", int'(flagWrEn), int'(mFw));
    if (mFw) check("R9 data", int'(flagWrData), int'(mFd));

    if (testReq) begin
      if (int'(testSel) == lastSel) engCnt++;
      else begin engCnt = 0; lastSel = int'(testSel); end
      done = (engCnt >= lat[testSel]) || stray;
      pass = stray ? 1'b1 : verdict[testSel];
    end else begin
      engCnt = 0; lastSel = -1;
      done = stray; pass = 1'b1;
    end
  end

  initial begin
    #(20000 * 10);
    nFails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    // S1: all pass, mixed latency
    setEngine(1);
    for (int i = 0; i < N; i++) lat[i] = i % 4;
    tmo = 16'd8; prior = 1'b0;
    doReset();
    waitCyc(60);
    check("R3 all pass", int'(pathEnable), 1);
    check("R6 pass code", int'(statusCode), 0);

    // S2: fail on SHA-256 (index 3)
    setEngine(1); verdict[3] = 1'b0;
    doReset();
    waitCyc(40);
    check("R4 fail code", int'(statusCode), 4);
    check("R6 closed on fail", int'(pathEnable), 0);

    // S3: stray responses in error state
    stray = 1'b1;
    waitCyc(6);
    stray = 1'b0;
    waitCyc(2);
    check("R7 sticky failed", int'(failed), 1);
    check("R7 sticky code", int'(statusCode), 4);

    // S4: prior failure plus failure on first test
    setEngine(1); verdict[0] = 1'b0; prior = 1'b1;
    doReset();
    waitCyc(10);
    check("R8 unrecoverable", int'(statusCode), 15);

    // S5: prior raised after start is ignored
    setEngine(1); verdict[6] = 1'b0; prior = 1'b0;
    doReset();
    waitCyc(3); prior = 1'b1;
    waitCyc(30);
    check("R8 late prior ignored", int'(statusCode), 7);

    // S6: response in last allowed cycle
    setEngine(4); tmo = 16'd5; prior = 1'b0;
    doReset();
    waitCyc(70);
    check("R5 boundary accepted", int'(pathEnable), 1);

    // S7: last test one cycle too late
    setEngine(4); lat[10] = 5;
    doReset();
    waitCyc(70);
    check("R5 timeout code", int'(statusCode), 11);

    // S8: zero timeout, immediate response passes, late one fails
    setEngine(0); lat[2] = 1; tmo = 16'd0;
    doReset();
    waitCyc(10);
    check("R5 zero timeout", int'(statusCode), 3);

    // S9: reset in the middle of a run restarts at first test
    setEngine(2); tmo = 16'd8;
    doReset();
    waitCyc(10);
    doReset();
    waitCyc(40);
    check("R3 restart pass", int'(pathEnable), 1);

    // S10: passing run with prior failure clears flag
    setEngine(1); prior = 1'b1;
    doReset();
    waitCyc(30);
    check("R9 clear after pass", int'(pathEnable), 1);
    check("R8 prior pass code", int'(statusCode), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule